// File: doc/BRIEF.md
# Two-Port Semaphore Bank

This block holds a set of hardware tokens shared between a left and a right port. It sits beside a shared data memory but keeps no data of its own. Software on either side claims a token to mark a shared resource as taken, checks whether the claim succeeded, and hands the token back when done. Each token is a small ownership latch. It also remembers whether the other side is waiting for it, and passes ownership to that side on release without another request.

Every port has a token select, a data-memory enable, a write strobe, an address bus and a data bus in each direction. An access is a single synchronous cycle sampled on the rising clock edge. Only the low address bits choose the token, and only data bit 0 carries a write. A read reports the token from the reading side's point of view: 0 when that side holds the token, 1 in every other case. The value is copied onto every data bit and held in an output register.

Top module: `dual_port_token_bank`

## Requirements
- R1: After reset every token is free with no waiting request, and both read-data outputs are all ones until their first read.
- R2: The token index is the low log2(NUM_SEMS) address bits (3 bits by default). Upper address bits are ignored, and tokens do not affect one another.
- R3: A write looks only at data bit 0: 0 requests the token, and 1 releases it or withdraws a waiting request. All other data bits are ignored.
- R4: A read returns all zeros on the data bus when the reading port owns the token and all ones otherwise. The value appears after the clock edge that samples the read and holds until that port's next accepted read.
- R5: A request on a free token grants it at that edge. The other port then reads 1.
- R6: A request from the non-owning port does not change ownership but is remembered. When the owner writes 1, ownership passes at that edge to the waiting port. A repeated request by the owner has no effect.
- R7: A non-owner that writes 1 withdraws its waiting request, so a later release by the owner leaves the token free.
- R8: When both ports request the same free token in the same cycle, the left port gets it and the right port's request is remembered as waiting.
- R9: An access is accepted only when the token select is 1 and the data-memory enable is 0. With both at 1, the access is ignored: no token changes and the read data is not updated.
- R10: A read captures the token state from before the edge, even when the other port writes the same token at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sem_sel | input | 1 | Left token access select |
| l_ram_en | input | 1 | Left data-memory enable; blocks token access when 1 |
| l_wr | input | 1 | Left write strobe (1 write, 0 read) |
| l_addr | input | ADDR_W | Left address; low bits choose the token |
| l_wdata | input | DATA_W | Left write data; bit 0 used |
| l_rdata | output | DATA_W | Left registered read data |
| r_sem_sel | input | 1 | Right token access select |
| r_ram_en | input | 1 | Right data-memory enable; blocks token access when 1 |
| r_wr | input | 1 | Right write strobe (1 write, 0 read) |
| r_addr | input | ADDR_W | Right address; low bits choose the token |
| r_wdata | input | DATA_W | Right write data; bit 0 used |
| r_rdata | output | DATA_W | Right registered read data |

## Verification
The assertions assume that each port presents at most one access per cycle, that it is sampled at the rising edge and held stable around that edge, and that reset is asserted from time zero. They make no other assumption about the two sides, so same-cycle collisions and the illegal select-plus-enable case are legal stimulus. The bench changes all inputs on the falling edge. It mixes directed sequences with a random phase in which both ports hit the same few tokens with requests, releases, reads and ignored accesses.

// File: rtl/token_bank_pkg.sv
package token_bank_pkg;

   typedef enum logic [1:0] {
      OWN_NONE  = 2'b00,
      OWN_LEFT  = 2'b01,
      OWN_RIGHT = 2'b10
   } owner_t;

   typedef struct packed {
      logic take;
      logic drop;
   } tok_cmd_t;

endpackage

// File: rtl/token_port_decode.sv
module token_port_decode
   import token_bank_pkg::*;
#(
   parameter int NUM_SEMS = 8,
   parameter int ADDR_W   = 13,
   parameter int DATA_W   = 8,
   localparam int IDX_W   = $clog2(NUM_SEMS)
) (
   input  logic                       sel,
   input  logic                       ram_en,
   input  logic                       wr,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   output tok_cmd_t [NUM_SEMS-1:0]    cmd,
   output logic                       rd_fire,
   output logic [IDX_W-1:0]           rd_idx
);

   logic             acc;
   logic [IDX_W-1:0] idx;
   logic             unused_bits;

   // token access only with the data-memory enable idle
   assign acc         = sel & ~ram_en;
   assign idx         = addr[IDX_W-1:0];
   assign rd_fire     = acc & ~wr;
   assign rd_idx      = idx;
   assign unused_bits = ^{addr, wdata};

   for (genvar g = 0; g < NUM_SEMS; g++) begin : g_slot
      logic hit;
      assign hit         = acc & wr & (idx == IDX_W'(g));
      assign cmd[g].take = hit & ~wdata[0];
      assign cmd[g].drop = hit &  wdata[0];
   end

endmodule

// File: rtl/token_cell.sv
module token_cell
   import token_bank_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  tok_cmd_t cmd_l,
   input  tok_cmd_t cmd_r,
   output logic     held_l,
   output logic     held_r
);

   owner_t owner_q, owner_d;
   logic   wait_q, wait_d;

   always_comb begin
      owner_d = owner_q;
      wait_d  = wait_q;
      unique case (owner_q)
         OWN_NONE: begin
            wait_d = 1'b0;
            if (cmd_l.take) begin
               owner_d = OWN_LEFT;
               wait_d  = cmd_r.take;
            end else if (cmd_r.take) begin
               owner_d = OWN_RIGHT;
            end
         end
         OWN_LEFT: begin
            if (cmd_l.drop) begin
               wait_d = 1'b0;
               if ((wait_q && !cmd_r.drop) || cmd_r.take) owner_d = OWN_RIGHT;
               else                                       owner_d = OWN_NONE;
            end else if (cmd_r.take) begin
               wait_d = 1'b1;
            end else if (cmd_r.drop) begin
               wait_d = 1'b0;
            end
         end
         OWN_RIGHT: begin
            if (cmd_r.drop) begin
               wait_d = 1'b0;
               if ((wait_q && !cmd_l.drop) || cmd_l.take) owner_d = OWN_LEFT;
               else                                       owner_d = OWN_NONE;
            end else if (cmd_l.take) begin
               wait_d = 1'b1;
            end else if (cmd_l.drop) begin
               wait_d = 1'b0;
            end
         end
         default: begin
            owner_d = OWN_NONE;
            wait_d  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= OWN_NONE;
         wait_q  <= 1'b0;
      end else begin
         owner_q <= owner_d;
         wait_q  <= wait_d;
      end
   end

   assign held_l = (owner_q == OWN_LEFT);
   assign held_r = (owner_q == OWN_RIGHT);

endmodule

// File: rtl/token_read_reg.sv
module token_read_reg #(
   parameter int NUM_SEMS = 8,
   parameter int DATA_W   = 8,
   localparam int IDX_W   = $clog2(NUM_SEMS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fire,
   input  logic [IDX_W-1:0]    idx,
   input  logic [NUM_SEMS-1:0] held,
   output logic [DATA_W-1:0]   rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata <= '1;
      else if (fire) rdata <= {DATA_W{~held[idx]}};
   end

endmodule

// File: rtl/dual_port_token_bank.sv
module dual_port_token_bank
   import token_bank_pkg::*;
#(
   parameter int NUM_SEMS = 8,
   parameter int ADDR_W   = 13,
   parameter int DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sem_sel,
   input  logic              l_ram_en,
   input  logic              l_wr,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_sem_sel,
   input  logic              r_ram_en,
   input  logic              r_wr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata
);

   localparam int IDX_W = $clog2(NUM_SEMS);

   if (NUM_SEMS < 2 || (NUM_SEMS & (NUM_SEMS - 1)) != 0) begin : g_bad_count
      $error("NUM_SEMS must be a power of two of at least 2");
   end
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the token index");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   tok_cmd_t [NUM_SEMS-1:0] cmd_l, cmd_r;
   logic                    l_fire, r_fire;
   logic [IDX_W-1:0]        l_idx, r_idx;
   logic [NUM_SEMS-1:0]     held_l, held_r;

   token_port_decode #(.NUM_SEMS(NUM_SEMS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
      .sel(l_sem_sel), .ram_en(l_ram_en), .wr(l_wr), .addr(l_addr), .wdata(l_wdata),
      .cmd(cmd_l), .rd_fire(l_fire), .rd_idx(l_idx)
   );

   token_port_decode #(.NUM_SEMS(NUM_SEMS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
      .sel(r_sem_sel), .ram_en(r_ram_en), .wr(r_wr), .addr(r_addr), .wdata(r_wdata),
      .cmd(cmd_r), .rd_fire(r_fire), .rd_idx(r_idx)
   );

   for (genvar s = 0; s < NUM_SEMS; s++) begin : g_tok
      token_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .cmd_l(cmd_l[s]), .cmd_r(cmd_r[s]),
         .held_l(held_l[s]), .held_r(held_r[s])
      );
   end

   token_read_reg #(.NUM_SEMS(NUM_SEMS), .DATA_W(DATA_W)) u_rd_l (
      .clk(clk), .rst_n(rst_n), .fire(l_fire), .idx(l_idx), .held(held_l), .rdata(l_rdata)
   );

   token_read_reg #(.NUM_SEMS(NUM_SEMS), .DATA_W(DATA_W)) u_rd_r (
      .clk(clk), .rst_n(rst_n), .fire(r_fire), .idx(r_idx), .held(held_r), .rdata(r_rdata)
   );

endmodule

// File: rtl/token_bank_chk.sv
module token_bank_chk #(
   parameter int NUM_SEMS = 8,
   parameter int ADDR_W   = 13,
   parameter int DATA_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                l_sem_sel,
   input logic                l_ram_en,
   input logic                l_wr,
   input logic [ADDR_W-1:0]   l_addr,
   input logic [DATA_W-1:0]   l_wdata,
   input logic [DATA_W-1:0]   l_rdata,
   input logic                r_sem_sel,
   input logic                r_ram_en,
   input logic                r_wr,
   input logic [ADDR_W-1:0]   r_addr,
   input logic [DATA_W-1:0]   r_wdata,
   input logic [DATA_W-1:0]   r_rdata,
   input logic [NUM_SEMS-1:0] held_l,
   input logic [NUM_SEMS-1:0] held_r
);

   localparam int IDX_W = $clog2(NUM_SEMS);

   logic             l_acc, r_acc, l_take, r_take, li_free, ri_free;
   logic [IDX_W-1:0] li, ri;
   logic             unused_chk;

   assign l_acc      = l_sem_sel && !l_ram_en;
   assign r_acc      = r_sem_sel && !r_ram_en;
   assign li         = l_addr[IDX_W-1:0];
   assign ri         = r_addr[IDX_W-1:0];
   assign l_take     = l_acc && l_wr && !l_wdata[0];
   assign r_take     = r_acc && r_wr && !r_wdata[0];
   assign li_free    = !held_l[li] && !held_r[li];
   assign ri_free    = !held_l[ri] && !held_r[ri];
   assign unused_chk = ^{l_addr, r_addr, l_wdata, r_wdata};

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |=> (held_l == '0 && held_r == '0));

   // R4
   l_rdata_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rdata == '0 || l_rdata == '1));

   // R4
   r_rdata_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (r_rdata == '0 || r_rdata == '1));

   // R6
   single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((held_l & held_r) == '0));

   // R5
   l_grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_take && li_free) |=> held_l[$past(li)]);

   // R5
   r_grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (r_take && ri_free && !(l_take && li == ri)) |=> held_r[$past(ri)]);

   // R8
   tie_left_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_take && r_take && li == ri && li_free) |=> (held_l[$past(li)] && !held_r[$past(li)]));

   // R9
   l_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sem_sel && l_ram_en && !r_acc) |=> ($stable(held_l) && $stable(held_r) && $stable(l_rdata)));

   // R9
   r_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (r_sem_sel && r_ram_en && !l_acc) |=> ($stable(held_l) && $stable(held_r) && $stable(r_rdata)));

endmodule

bind dual_port_token_bank token_bank_chk #(
   .NUM_SEMS(NUM_SEMS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/dual_port_token_bank_test.sv
module dual_port_token_bank_test;

   localparam int NS = 8;
   localparam int AW = 13;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          l_sem_sel = 1'b0, l_ram_en = 1'b0, l_wr = 1'b0;
   logic [AW-1:0] l_addr = '0;
   logic [DW-1:0] l_wdata = '0;
   logic [DW-1:0] l_rdata;
   logic          r_sem_sel = 1'b0, r_ram_en = 1'b0, r_wr = 1'b0;
   logic [AW-1:0] r_addr = '0;
   logic [DW-1:0] r_wdata = '0;
   logic [DW-1:0] r_rdata;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   dual_port_token_bank #(.NUM_SEMS(NS), .ADDR_W(AW), .DATA_W(DW)) uut (.*);

   // behavioural reference: owner 0 free, 1 left, 2 right
   int            m_own  [NS];
   bit            m_wait [NS];
   logic [DW-1:0] m_lrd, m_rrd;
   bit            model_on = 1'b0;

   task automatic m_write(input int who, input int idx, input bit v);
      if (v == 1'b0) begin
         if (m_own[idx] == 0)        m_own[idx] = who;
         else if (m_own[idx] != who) m_wait[idx] = 1'b1;
      end else begin
         if (m_own[idx] == who) begin
            if (m_wait[idx]) m_own[idx] = 3 - who;
            else             m_own[idx] = 0;
            m_wait[idx] = 1'b0;
         end else if (m_own[idx] != 0) begin
            m_wait[idx] = 1'b0;
         end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) begin m_own[i] = 0; m_wait[i] = 1'b0; end
         m_lrd = '1;
         m_rrd = '1;
      end else begin
         int  li, ri;
         bit  la, ra;
         li = int'(l_addr) % NS;
         ri = int'(r_addr) % NS;
         la = l_sem_sel && !l_ram_en;
         ra = r_sem_sel && !r_ram_en;
         if (la && !l_wr) m_lrd = (m_own[li] == 1) ? '0 : '1;
         if (ra && !r_wr) m_rrd = (m_own[ri] == 2) ? '0 : '1;
         if (la && l_wr) m_write(1, li, l_wdata[0]);
         if (ra && r_wr) m_write(2, ri, r_wdata[0]);
      end
   end

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   // R4 model comparison on every clock
   always @(negedge clk) begin
      if (rst_n && model_on) begin
         check(l_rdata == m_lrd, "R4 model left", l_rdata, m_lrd);
         check(r_rdata == m_rrd, "R4 model right", r_rdata, m_rrd);
      end
   end

   task automatic idle();
      l_sem_sel = 0; l_ram_en = 0; l_wr = 0; l_addr = '0; l_wdata = '0;
      r_sem_sel = 0; r_ram_en = 0; r_wr = 0; r_addr = '0; r_wdata = '0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic set_l(input bit sel, input bit ram, input bit wr, input int addr, input int d);
      l_sem_sel = sel; l_ram_en = ram; l_wr = wr; l_addr = AW'(addr); l_wdata = DW'(d);
   endtask

   task automatic set_r(input bit sel, input bit ram, input bit wr, input int addr, input int d);
      r_sem_sel = sel; r_ram_en = ram; r_wr = wr; r_addr = AW'(addr); r_wdata = DW'(d);
   endtask

   task automatic wl(input int addr, input int d); set_l(1, 0, 1, addr, d); step(); endtask
   task automatic wr_(input int addr, input int d); set_r(1, 0, 1, addr, d); step(); endtask

   task automatic rd(input bit left, input int addr, input bit exp_one, input string tag);
      logic [DW-1:0] exp, got;
      if (left) set_l(1, 0, 0, addr, 0);
      else      set_r(1, 0, 0, addr, 0);
      step();
      exp = exp_one ? '1 : '0;
      got = left ? l_rdata : r_rdata;
      check(got == exp, tag, got, exp);
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      // R1 reset state on outputs
      check(l_rdata == '1, "R1 left rdata after reset", l_rdata, '1);
      check(r_rdata == '1, "R1 right rdata after reset", r_rdata, '1);
      rst_n = 1'b1;
      @(negedge clk);
      model_on = 1'b1;
      for (int i = 0; i < NS; i++) begin
         rd(1, i, 1'b1, "R1 left free");
         rd(0, i, 1'b1, "R1 right free");
      end

      // R5 grant on free
      wl(2, 0);
      rd(1, 2, 1'b0, "R5 left owns");
      rd(0, 2, 1'b1, "R5 right sees taken");
      // R6 denied, remembered, handed over
      wr_(2, 0);
      rd(0, 2, 1'b1, "R6 right denied");
      rd(1, 2, 1'b0, "R6 left still owns");
      wl(2, 0);
      rd(1, 2, 1'b0, "R6 repeat request by owner");
      wl(2, 1);
      rd(0, 2, 1'b0, "R6 handover to right");
      rd(1, 2, 1'b1, "R6 left released");
      wl(2, 0);
      wr_(2, 1);
      rd(1, 2, 1'b0, "R6 handover back to left");
      wl(2, 1);
      rd(1, 2, 1'b1, "R6 left free again");
      rd(0, 2, 1'b1, "R6 right free again");

      // R7 withdraw a waiting request
      wl(5, 0);
      wr_(5, 0);
      wr_(5, 1);
      wl(5, 1);
      rd(0, 5, 1'b1, "R7 right not granted after withdraw");
      rd(1, 5, 1'b1, "R7 token free");

      // R2 upper address bits ignored, tokens independent
      wl(13'h1FF9, 0);
      rd(1, 1, 1'b0, "R2 left owns index 1");
      rd(1, 0, 1'b1, "R2 index 0 untouched");
      rd(0, 13'h0A01, 1'b1, "R2 right aliased index 1");
      wl(13'h0401, 1);
      rd(1, 1, 1'b1, "R2 release through alias");

      // R3 only bit 0 of write data used
      wl(3, 8'hFE);
      rd(1, 3, 1'b0, "R3 FE requests");
      wl(3, 8'h01);
      rd(1, 3, 1'b1, "R3 01 releases");
      wr_(3, 8'hF0);
      rd(0, 3, 1'b0, "R3 F0 requests");
      wr_(3, 8'h0F);
      rd(0, 3, 1'b1, "R3 0F releases");

      // R8 same-cycle tie
      set_l(1, 0, 1, 4, 0);
      set_r(1, 0, 1, 4, 0);
      step();
      rd(1, 4, 1'b0, "R8 left wins tie");
      rd(0, 4, 1'b1, "R8 right loses tie");
      wl(4, 1);
      rd(0, 4, 1'b0, "R8 right was waiting");
      wr_(4, 1);

      // R9 blocked accesses
      set_l(1, 1, 1, 6, 0);
      step();
      rd(1, 6, 1'b1, "R9 blocked write no effect");
      wl(6, 0);
      rd(1, 6, 1'b0, "R9 left owns 6");
      set_l(1, 1, 0, 7, 0);
      step();
      check(l_rdata == '0, "R9 blocked read keeps rdata", l_rdata, '0);
      set_l(0, 0, 0, 7, 0);
      step();
      check(l_rdata == '0, "R9 unselected read keeps rdata", l_rdata, '0);
      wl(6, 1);

      // R10 read captures pre-edge state
      wl(7, 0);
      wr_(7, 0);
      set_l(1, 0, 1, 7, 1);
      set_r(1, 0, 0, 7, 0);
      step();
      check(r_rdata == '1, "R10 right reads pre-handover", r_rdata, '1);
      rd(0, 7, 1'b0, "R10 right owns after handover");
      wr_(7, 1);

      // random mix, checked against the model every clock
      for (int n = 0; n < 600; n++) begin
         set_l($urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1,
               int'($urandom_range(0, 8191)) & 13'h1FF3, int'($urandom_range(0, 255)));
         set_r($urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1,
               int'($urandom_range(0, 8191)) & 13'h1FF3, int'($urandom_range(0, 255)));
         step();
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule